// File: doc/BRIEF.md
# Serial Slave Address-Match Receiver

This block listens to the opening byte of a serial transaction. Bits arrive one per active edge of an externally supplied serial clock, on an input line that is separate from the output line. The first seven bits form a slave address, most significant bit first. The eighth bit is a direction flag. The block compares the received address with one of four preset addresses, chosen by a 2-bit select input. On a match it raises an acknowledge on its own output line for one clock.

A start pulse, sampled on the clock, opens a new address phase. An asynchronous reset does the same. After the eighth bit the block either acknowledges or goes quiet. It then waits in an idle phase until the next start. The latched direction flag and a phase indication remain visible on the outputs. The serial bit stream has no valid/ready handshake: every active clock edge carries one bit, so all pins are plain control and data lines with no back-pressure.

Top module: `addr_match_rx`

## Requirements
- R1: While the active-low reset is asserted, and on the first cycles after it is released, the phase output reads 1 (receiving), the acknowledge is 0 and the direction flag is 0.
- R2: In the receiving phase, each rising edge of the clock input shifts in the data bit. The first bit received is the address MSB, bits 1 to 7 are the address, and bit 8 is the direction bit.
- R3: The receiving phase ends on exactly the eighth clock edge after the start (or after reset) that carries data.
- R4: When the 7 received address bits equal the selected preset, the phase becomes 2 (acknowledge) and the acknowledge output is 1 for exactly the one clock that follows the eighth edge. The block then moves to phase 0 (idle). This happens for either value of the direction bit.
- R5: When the address does not match, the acknowledge stays 0 and the phase goes straight to 0 (idle) after the eighth edge.
- R6: The eighth bit is latched into the direction flag (1 = read, 0 = write) on the eighth edge, whether or not the address matched. The flag holds until the next start or reset, which clear it to 0.
- R7: Select value k (0 to 3) picks preset k, with defaults 0x1A, 0x2B, 0x3C and 0x4D. Select is used only on the eighth edge; its value during earlier bits has no effect.
- R8: A start sampled high on any edge clears the bit count and the shift register, clears the direction flag and enters phase 1. This applies in every phase, including mid-byte and during the acknowledge, and start takes priority over all other activity on that edge.
- R9: In the idle phase, changes on the data and select inputs have no effect: the phase stays 0 and the acknowledge stays 0 until a start.
- R10: The acknowledge output is 0 in every cycle except the single acknowledge clock of a matching address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scl_n_i | input | 1 | Inverted serial clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new address phase when high at a clock edge |
| sdi_i | input | 1 | Serial data in, one bit per clock edge, MSB first |
| sel_i | input | 2 | Selects which of the four preset addresses is compared |
| ack_o | output | 1 | Acknowledge, high for one clock on an address match |
| rw_o | output | 1 | Latched direction bit, 1 = read, 0 = write |
| phase_o | output | 2 | Phase: 0 idle, 1 receiving, 2 acknowledge |

## Verification
The hardest situations to reach from the ports are a restart that lands in the middle of a byte or in the acknowledge clock, and a select input that changes during the byte. In both, the outcome depends on exactly which edge carries the start or the final select value. The stimulus builds frames bit by bit, cuts some short with a new start after a chosen number of bits, and switches the select between the first seven bits and the eighth. A behavioural model follows the same edges and flags any divergence in phase, acknowledge or direction flag in the cycle it occurs. Addresses that belong to a non-selected preset, or that differ from the selected one only in the last bit, cover the near-miss cases.

// File: rtl/amr_pkg.sv
package amr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RECV = 2'd1,
    PH_ACK  = 2'd2
  } phase_e;
endpackage

// File: rtl/addr_shift.sv
module addr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      byte_o <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      byte_o <= {byte_o[BYTE_W-2:0], bit_i};
      cnt_q  <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == LAST_IDX);

  // R8
  clear_restarts_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !last_o);
endmodule

// File: rtl/addr_match.sv
module addr_match #(
  parameter int ADDR_W   = 7,
  parameter int NUM_ADDR = 4,
  parameter int SEL_W    = 2,
  parameter logic [NUM_ADDR-1:0][ADDR_W-1:0] PRESETS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              hit_o
);
  logic [NUM_ADDR-1:0] hit_vec;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
    assign hit_vec[g] = (addr_i == PRESETS[g]);
  end

  assign hit_o = hit_vec[sel_i];
endmodule

// File: rtl/phase_ctl.sv
module phase_ctl
  import amr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   last_i,
  input  logic   hit_i,
  input  logic   bit_i,
  output phase_e phase_o,
  output logic   rw_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_RECV;
      rw_o    <= 1'b0;
    end else if (start_i) begin
      phase_o <= PH_RECV;
      rw_o    <= 1'b0;
    end else begin
      unique case (phase_o)
        PH_RECV: if (last_i) begin
          phase_o <= hit_i ? PH_ACK : PH_IDLE;
          rw_o    <= bit_i;
        end
        PH_ACK:  phase_o <= PH_IDLE;
        default: phase_o <= PH_IDLE;
      endcase
    end
  end

  // R3
  recv_ends_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_RECV && last_i && !start_i) |=> phase_o != PH_RECV);

  // R4
  ack_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_ACK && !start_i) |=> phase_o == PH_IDLE);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_IDLE && !start_i) |=> phase_o == PH_IDLE);

  // R6
  rw_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != PH_RECV && !start_i) |=> $stable(rw_o));
endmodule

// File: rtl/addr_match_rx.sv
module addr_match_rx
  import amr_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int NUM_ADDR = 4,
  parameter logic [NUM_ADDR-1:0][ADDR_W-1:0] PRESETS =
    {7'h4D, 7'h3C, 7'h2B, 7'h1A}
) (
  input  logic       scl_n_i,
  input  logic       rst_n_i,
  input  logic       start_i,
  input  logic       sdi_i,
  input  logic [1:0] sel_i,
  output logic       ack_o,
  output logic       rw_o,
  output logic [1:0] phase_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int SEL_W  = $clog2(NUM_ADDR);

  phase_e            phase;
  logic [BYTE_W-1:0] byte_q;
  logic              last;
  logic              hit;
  logic              shift_en;

  assign shift_en = (phase == PH_RECV) && !start_i;

  addr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk    (scl_n_i),
    .rst_n  (rst_n_i),
    .clr_i  (start_i),
    .en_i   (shift_en),
    .bit_i  (sdi_i),
    .byte_o (byte_q),
    .last_o (last)
  );

  addr_match #(
    .ADDR_W   (ADDR_W),
    .NUM_ADDR (NUM_ADDR),
    .SEL_W    (SEL_W),
    .PRESETS  (PRESETS)
  ) u_match (
    .addr_i (byte_q[ADDR_W-1:0]),
    .sel_i  (sel_i[SEL_W-1:0]),
    .hit_o  (hit)
  );

  phase_ctl u_ctl (
    .clk     (scl_n_i),
    .rst_n   (rst_n_i),
    .start_i (start_i),
    .last_i  (last),
    .hit_i   (hit),
    .bit_i   (sdi_i),
    .phase_o (phase),
    .rw_o    (rw_o)
  );

  assign ack_o   = (phase == PH_ACK);
  assign phase_o = phase;

  // R10
  ack_single_clock_chk: assert property (@(posedge scl_n_i) disable iff (!rst_n_i)
    ack_o |=> !ack_o);

  // R4
  ack_needs_eighth_bit_chk: assert property (@(posedge scl_n_i) disable iff (!rst_n_i)
    $rose(ack_o) |-> $past(last && phase == PH_RECV && !start_i));
endmodule

// File: tb/addr_match_rx_tb_top.sv
module addr_match_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sdi = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       ack;
  logic       rw;
  logic [1:0] phase;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  int presets [4] = '{'h1A, 'h2B, 'h3C, 'h4D};
  int m_phase = 1;
  int m_cnt   = 0;
  int m_byte  = 0;
  int m_rw    = 0;

  always #4 clk = ~clk;

  addr_match_rx dut_i (
    .scl_n_i (clk),
    .rst_n_i (rst_n),
    .start_i (start),
    .sdi_i   (sdi),
    .sel_i   (sel),
    .ack_o   (ack),
    .rw_o    (rw),
    .phase_o (phase)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 1; m_cnt = 0; m_byte = 0; m_rw = 0;
    end else if (start) begin
      m_phase = 1; m_cnt = 0; m_byte = 0; m_rw = 0;
    end else if (m_phase == 1) begin
      m_byte = ((m_byte << 1) | int'(sdi)) & 255;
      if (m_cnt == 7) begin
        m_rw    = int'(sdi);
        m_phase = ((m_byte >> 1) == presets[sel]) ? 2 : 0;
        m_cnt   = 0;
      end else begin
        m_cnt++;
      end
    end else begin
      m_phase = 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    check(tag, "phase", int'(phase), m_phase);
    check(tag, "ack",   int'(ack),   (m_phase == 2) ? 1 : 0);
    check(tag, "rw",    int'(rw),    m_rw);
  end

  task automatic drive(logic st, logic d, logic [1:0] s);
    @(negedge clk);
    start = st; sdi = d; sel = s;
  endtask

  // start, then nbits of {addr, rw}; sel_early used before the last bit
  task automatic frame(int addr, logic dir, logic [1:0] s, logic [1:0] sel_early, int nbits);
    logic [7:0] b;
    b = {addr[6:0], dir};
    drive(1'b1, 1'b0, sel_early);
    for (int i = 7; i > 7 - nbits; i--)
      drive(1'b0, b[i], (i == 0) ? s : sel_early);
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++)
      drive(1'b0, 1'($urandom), 2'($urandom));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    tag = "R1";
    check("R1", "phase in reset", int'(phase), 1);
    check("R1", "ack in reset", int'(ack), 0);
    check("R1", "rw in reset", int'(rw), 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 2'd0);

    tag = "R2 R4"; frame('h1A, 1'b0, 2'd0, 2'd0, 8); idle_noise(2);
    tag = "R4 R6"; frame('h2B, 1'b1, 2'd1, 2'd1, 8); idle_noise(2);
    tag = "R5";    frame('h2A, 1'b0, 2'd1, 2'd1, 8); idle_noise(2);
    tag = "R5 R6"; frame('h1B, 1'b1, 2'd0, 2'd0, 8); idle_noise(2);
    for (int k = 0; k < 4; k++) begin
      tag = "R7"; frame(presets[k], 1'(k), 2'(k), 2'(k), 8); idle_noise(2);
      tag = "R7"; frame(presets[k], 1'b0, 2'(k + 1), 2'(k), 8); idle_noise(2);
    end
    tag = "R7"; frame('h3C, 1'b1, 2'd2, 2'd0, 8); idle_noise(2);
    tag = "R3"; frame('h4D, 1'b0, 2'd3, 2'd3, 7); drive(1'b0, 1'b1, 2'd3); idle_noise(2);
    tag = "R8"; frame('h1A, 1'b1, 2'd0, 2'd0, 4);
    frame('h1A, 1'b1, 2'd0, 2'd0, 8);
    tag = "R8"; frame('h2B, 1'b0, 2'd1, 2'd1, 8);
    frame('h3C, 1'b1, 2'd2, 2'd2, 8); idle_noise(2);
    tag = "R9 R10"; idle_noise(20);
    tag = "R6 R8"; drive(1'b1, 1'b0, 2'd0); idle_noise(1);
    tag = "R10";
    for (int n = 0; n < 200; n++) begin
      frame(($urandom % 3 == 0) ? presets[n % 4] : int'($urandom % 128),
            1'($urandom), 2'(n % 4), 2'($urandom), 1 + int'($urandom % 8));
      idle_noise(int'($urandom % 3));
    end
    drive(1'b0, 1'b0, 2'd0);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule